// File: doc/BRIEF.md
# Configurable External Interrupt Controller

This block turns general-purpose I/O pins into processor interrupt requests over two independent channels. Each channel picks one pin through its own select field, passes it through a two-flop synchroniser, and watches it for a rising edge, a falling edge, a high level or a low level. The channels sit alongside the wakeup event inputs and have nothing to do with them.

Software configures each channel through a small word-addressed register port. It reads back the pending flags and the synchronised pin levels, and clears pending flags by writing ones. Edge detections are latched until software clears them. A level request follows the pin and cannot be cleared while the level is still present. Writing a channel's configuration discards its edge history, so retargeting a channel never produces a false edge. The register port is plain control: one write strobe, one address and a combinational read, with no handshake.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and every `irq_o` bit is 0.
- R2: Trigger code 00 (rising). A 0-to-1 change on the selected pin sets the channel's pending bit. The bit is visible on the third rising clock edge after the pin change, and `irq_o` asserts with it.
- R3: Trigger code 01 (falling). A 1-to-0 change on the selected pin sets the pending bit and `irq_o`, with the same latency as R2.
- R4: In the edge modes the pending bit stays set after the pin returns. Writing 0 to its status bit leaves it set. Writing 1 clears it, and `irq_o` then drops.
- R5: Trigger code 10 (high level). `irq_o` is 1 while the enabled channel's synchronised pin is 1 and 0 once it has returned to 0.
- R6: Trigger code 11 (low level). `irq_o` is 1 while the enabled channel's synchronised pin is 0.
- R7: In the level modes, a write of 1 to the pending bit is ignored while the level is still active. Once the level has gone, the write clears the bit.
- R8: Only the pin named by a channel's select field affects that channel. Activity on any other pin is ignored.
- R9: A write to a channel's configuration register clears its edge history. If the newly selected pin differs from the old one, no edge is reported.
- R10: A channel whose enable bit is 0 never sets its pending bit, and its `irq_o` bit stays 0.
- R11: The channels are independent. Activity on one channel never sets the other channel's pending bit.
- R12: Register map:
  - Address c (for c < NUM_CH) is channel c's configuration: bit 0 enable, bits 2:1 trigger code, bits 8 and up the pin select. It reads back exactly what was written.
  - Address NUM_CH holds the pending bits, one per channel at bit c. Writing 1 to a bit clears it.
  - Address NUM_CH+1 holds the synchronised level of each channel's selected pin at bit c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | NUM_PINS | Asynchronous general-purpose pin levels |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address (shared by reads and writes) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq_o | output | NUM_CH | Interrupt request per channel |

## Verification
The bench builds the block with NUM_PINS = 8 and the default two channels. This is small enough to sweep every channel, every trigger code and every pin select exhaustively. In each of the 64 combinations, a neighbouring pin is driven first, then the selected pin. That brings the select, latency, stickiness and clear-while-active rules into reach for every combination. Directed cases cover reconfiguration onto a differently valued pin, a disabled channel and configuration readback.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    TRG_RISE = 2'b00,
    TRG_FALL = 2'b01,
    TRG_HIGH = 2'b10,
    TRG_LOW  = 2'b11
  } trig_e;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_TRIG_LSB = 1;
  localparam int CFG_SEL_LSB  = 8;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= async_i[i];
        stage2 <= stage1;
      end
    end
    assign sync_o[i] = stage2;
  end
endmodule

// File: rtl/eirq_channel.sv
module eirq_channel
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_s,
  input  logic                en,
  input  logic [1:0]          trig,
  input  logic [SEL_W-1:0]    sel,
  input  logic                cfg_wr,
  input  logic                clr,
  output logic                level_o,
  output logic                pend_o,
  output logic                irq_o
);
  trig_e mode;
  logic  cur, prev, armed;
  logic  rise, fall, lvl_act, is_level, hit;
  logic  pend_q;

  assign mode = trig_e'(trig);

  always_comb begin
    cur = 1'b0;
    if (int'(sel) < NUM_PINS) cur = pins_s[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      armed <= 1'b0;
    end else begin
      prev  <= cur;
      armed <= !cfg_wr;
    end
  end

  assign rise     = armed && !prev && cur;
  assign fall     = armed && prev && !cur;
  assign is_level = (mode == TRG_HIGH) || (mode == TRG_LOW);
  assign lvl_act  = ((mode == TRG_HIGH) && cur) || ((mode == TRG_LOW) && !cur);

  always_comb begin
    unique case (mode)
      TRG_RISE: hit = en && rise;
      TRG_FALL: hit = en && fall;
      default:  hit = en && lvl_act;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (hit)   pend_q <= 1'b1;
    else if (clr)   pend_q <= 1'b0;
  end

  assign level_o = cur;
  assign pend_o  = pend_q;
  assign irq_o   = en && (is_level ? lvl_act : pend_q);
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  input  logic [NUM_CH-1:0]      pend,
  input  logic [NUM_CH-1:0]      lvl,
  output logic [NUM_CH-1:0]      en,
  output logic [NUM_CH-1:0][1:0] trig,
  output logic [NUM_CH-1:0][SEL_W-1:0] sel,
  output logic [NUM_CH-1:0]      cfg_wr,
  output logic [NUM_CH-1:0]      clr
);
  localparam logic [ADDR_W-1:0] ADDR_PEND = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] ADDR_LVL  = ADDR_W'(NUM_CH + 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    assign cfg_wr[c] = wr_en && (addr == ADDR_W'(c));
    assign clr[c]    = wr_en && (addr == ADDR_PEND) && wdata[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en[c]   <= 1'b0;
        trig[c] <= 2'b00;
        sel[c]  <= '0;
      end else if (cfg_wr[c]) begin
        en[c]   <= wdata[CFG_EN_BIT];
        trig[c] <= wdata[CFG_TRIG_LSB +: 2];
        sel[c]  <= wdata[CFG_SEL_LSB +: SEL_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_PEND) begin
      rdata[NUM_CH-1:0] = pend;
    end else if (addr == ADDR_LVL) begin
      rdata[NUM_CH-1:0] = lvl;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr == ADDR_W'(c)) begin
          rdata[CFG_EN_BIT]             = en[c];
          rdata[CFG_TRIG_LSB +: 2]      = trig[c];
          rdata[CFG_SEL_LSB +: SEL_W]   = sel[c];
        end
      end
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NUM_PINS = 16,
  parameter int NUM_CH   = 2,
  parameter int DATA_W   = 32,
  localparam int SEL_W   = $clog2(NUM_PINS),
  localparam int ADDR_W  = $clog2(NUM_CH + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                reg_wr_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [NUM_CH-1:0]   irq_o
);
  logic [NUM_PINS-1:0]           pins_s;
  logic [NUM_CH-1:0]             ch_en, ch_cfg_wr, ch_clr, ch_pend, ch_lvl;
  logic [NUM_CH-1:0][1:0]        ch_trig;
  logic [NUM_CH-1:0][SEL_W-1:0]  ch_sel;

  eirq_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pins_i), .sync_o(pins_s)
  );

  eirq_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .pend(ch_pend), .lvl(ch_lvl),
    .en(ch_en), .trig(ch_trig), .sel(ch_sel), .cfg_wr(ch_cfg_wr), .clr(ch_clr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    eirq_channel #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .pins_s(pins_s),
      .en(ch_en[c]), .trig(ch_trig[c]), .sel(ch_sel[c]),
      .cfg_wr(ch_cfg_wr[c]), .clr(ch_clr[c]),
      .level_o(ch_lvl[c]), .pend_o(ch_pend[c]), .irq_o(irq_o[c])
    );
  end
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int NUM_CH = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CH-1:0]      irq_o,
  input logic [NUM_CH-1:0]      ch_en,
  input logic [NUM_CH-1:0][1:0] ch_trig,
  input logic [NUM_CH-1:0]      ch_pend,
  input logic [NUM_CH-1:0]      ch_lvl,
  input logic [NUM_CH-1:0]      ch_cfg_wr,
  input logic [NUM_CH-1:0]      ch_clr
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    AST_DISABLED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[c] |-> !irq_o[c]); // R10
    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_pend[c]) |-> $past(ch_en[c])); // R10
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_pend[c] && !ch_clr[c]) |=> ch_pend[c]); // R4
    AST_LEVEL_HOLDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[c] && ch_trig[c][1] && (ch_lvl[c] ^ ch_trig[c][0])) |=> ch_pend[c]); // R7
    AST_RECFG_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cfg_wr[c] ##1 (!ch_pend[c] && !ch_trig[c][1]) |=> !ch_pend[c]); // R9
  end
endmodule

bind ext_irq_ctrl ext_irq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .ch_en(ch_en), .ch_trig(ch_trig),
  .ch_pend(ch_pend), .ch_lvl(ch_lvl), .ch_cfg_wr(ch_cfg_wr), .ch_clr(ch_clr)
);

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
  localparam int NP = 8;
  localparam int NC = 2;
  localparam int AW = $clog2(NC + 2);
  localparam int A_PEND = NC;
  localparam int A_LVL  = NC + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl #(.NUM_PINS(NP), .NUM_CH(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_wr_en(wr_en),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [31:0] cfg(input bit en, input int tr, input int sel);
    return 32'(en) | 32'(tr << 1) | 32'(sel << 8);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    clk_n(3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < NC + 2; a++) begin
      rd(a, d);
      check($sformatf("R1 reg%0d", a), d, 0);
    end
    check("R1 irq", 32'(irq), 0);

    // R12 configuration readback
    wr(0, cfg(1, 2, 5));
    rd(0, d); check("R12 cfg0 readback", d, cfg(1, 2, 5));
    wr(1, cfg(0, 3, 7));
    rd(1, d); check("R12 cfg1 readback", d, cfg(0, 3, 7));
    wr(0, 0); wr(1, 0);

    // Exhaustive sweep: channel x trigger x select
    for (int ch = 0; ch < NC; ch++) begin
      for (int tr = 0; tr < 4; tr++) begin
        for (int sel = 0; sel < NP; sel++) begin
          string tg;
          bit act, lvlm;
          int other, nb;
          act   = (tr == 0 || tr == 2);
          lvlm  = (tr >= 2);
          other = 1 - ch;
          nb    = sel ^ 1;
          tg = (tr == 0) ? "R2" : (tr == 1) ? "R3" : (tr == 2) ? "R5" : "R6";
          @(negedge clk) pins = act ? '0 : '1;
          wr(other, 0);
          wr(ch, cfg(1, tr, sel));
          clk_n(4);
          wr(A_PEND, 32'h3);
          rd(A_PEND, d); check("R9 setup pend clear", d, 0);
          check("R10 idle irq", 32'(irq), 0);

          @(negedge clk) pins[nb] = act;
          clk_n(4);
          rd(A_PEND, d); check("R8 unselected pin ignored", d, 0);
          check("R8 irq unselected", 32'(irq[ch]), 0);

          @(negedge clk) pins[sel] = act;
          clk_n(3);
          rd(A_PEND, d); check({tg, " pend set"}, 32'(d[ch]), 1);
          check("R11 other channel quiet", 32'(d[other]), 0);
          check({tg, " irq set"}, 32'(irq[ch]), 1);
          rd(A_LVL, d); check("R12 level readback", 32'(d[ch]), 32'(act));

          if (!lvlm) begin
            @(negedge clk) pins[sel] = !act;
            clk_n(3);
            check("R4 irq sticky", 32'(irq[ch]), 1);
            wr(A_PEND, 0);
            rd(A_PEND, d); check("R4 zero write keeps", 32'(d[ch]), 1);
            wr(A_PEND, 32'(1 << ch));
            rd(A_PEND, d); check("R4 w1c clears", 32'(d[ch]), 0);
            check("R4 irq drops", 32'(irq[ch]), 0);
          end else begin
            wr(A_PEND, 32'(1 << ch));
            rd(A_PEND, d); check("R7 clear while active", 32'(d[ch]), 1);
            @(negedge clk) pins[sel] = !act;
            clk_n(3);
            check({tg, " irq follows level"}, 32'(irq[ch]), 0);
            wr(A_PEND, 32'(1 << ch));
            rd(A_PEND, d); check("R7 clear after level", 32'(d[ch]), 0);
          end
        end
      end
    end

    // R9 reconfiguration onto a pin at a different level
    wr(1, 0);
    @(negedge clk) pins = 8'b0000_0010;
    wr(0, cfg(1, 0, 0));
    clk_n(4);
    wr(A_PEND, 32'h3);
    wr(0, cfg(1, 0, 1));
    clk_n(4);
    rd(A_PEND, d); check("R9 no edge from reselect", d, 0);
    wr(0, cfg(1, 1, 0));
    clk_n(4);
    rd(A_PEND, d); check("R9 no edge from retrigger", d, 0);

    // R10 disabled channel
    wr(0, cfg(0, 0, 2));
    clk_n(3);
    @(negedge clk) pins[2] = 1'b1;
    clk_n(4);
    rd(A_PEND, d); check("R10 disabled pend", d, 0);
    check("R10 disabled irq", 32'(irq), 0);
    wr(0, cfg(0, 2, 2));
    clk_n(3);
    check("R10 disabled level irq", 32'(irq), 0);

    finish_run();
  end
endmodule